// File: doc/BRIEF.md
# Host-Strobed Remote DMA Data Port

This block lets a host move bytes between a local packet memory and a host-visible data port without addressing the memory directly. The host loads a remote start address and a byte count through byte-wide registers. It then writes a direction code into the command register, and the engine arms a transfer. After that, every strobe on the data port moves one unit between the port and memory at the current remote address. After each unit the address steps forward and the count steps back.

When the count runs out, the engine returns to idle and raises a completion flag. The flag drives the interrupt output, and the host clears it by writing a 1 to its bit. A configuration bit selects byte or 16-bit units. In 16-bit mode the count is rounded up to an even value when the transfer is armed. A stop command halts the engine and reports the halt in a status bit. The packet memory is a plain single-port byte array inside the block.

Top module: `rdma_port_engine`

## Requirements
- R1: After reset, every register reads as zero, except the command register, which reads 0x02. The interrupt output is low and no transfer is armed.
- R2: Register offsets are fixed as follows. Offset 1 is the address low byte and offset 2 is the address high byte. Offset 3 is the count low byte and offset 4 is the count high byte. A host write to any of these four offsets loads that byte, and a read returns the current value.
- R3: Command code 0x10 in bits [5:3] arms a remote write. Each data-port write strobe then stores `port_wdata[7:0]` at the current address, adds 1 to the address and subtracts 1 from the count.
- R4: Command code 0x08 arms a remote read. While it is armed, `port_rdata` shows the byte at the current address, zero-extended. Each read strobe advances the address and count the same way as a write.
- R5: Completion sets status bit 6 (offset 5) and the `irq` output. Completion occurs when the count reaches zero, or when a transfer is armed with a count of zero. On completion the engine returns to idle. Writing 1 to bit 6 clears the flag, and writing 0 leaves it set.
- R6: Bit 0 of the configuration register (offset 6) selects 16-bit units. In this mode the low byte sits at the even address and the high byte at the odd address, and the address advances by 2 per strobe.
- R7: In 16-bit mode, arming a transfer rounds an odd count up by one.
- R8: Command code 0x20 (any write with bit 5 set) disarms a transfer at once. It does not set the completion flag.
- R9: Data-port strobes have no effect on memory, address or count while no transfer is armed. While no read is armed, `port_rdata` is zero.
- R10: The address registers return the live address while a transfer is in progress.
- R11: Command bit 0 (stop) disarms any transfer and sets status bit 7. A command write with bit 1 (start) and without bit 0 clears bit 7.
- R12: Command code 0x18 arms no transfer and leaves the count unchanged.
- R13: The command register reads back as follows. Bits [5:3] are 001 while a read is armed, 010 while a write is armed and 000 when idle. Bit 1 is the inverse of the stopped flag and bit 0 is the stopped flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Host register offset |
| reg_we | input | 1 | Host register write strobe |
| reg_wdata | input | 8 | Host register write data |
| reg_rdata | output | 8 | Host register read data (combinational) |
| port_rd | input | 1 | Data-port read strobe |
| port_wr | input | 1 | Data-port write strobe |
| port_wdata | input | 16 | Data-port write data |
| port_rdata | output | 16 | Data-port read data (combinational) |
| irq | output | 1 | Completion interrupt, equal to status bit 6 |

## Verification
The bench targets the following corner cases:
- The final strobe of a transfer. A design with an off-by-one count would raise the interrupt one strobe early or late.
- An odd count armed in 16-bit mode. If the count were not rounded, the last word would be lost or the count would never reach zero.
- Byte placement within a word. A swapped lane would surface when a byte-mode read fetches the odd address.
- Abort, stop, the send code and zero-count arming. Each is checked for the flag it must or must not set.
- Stray port strobes while idle. A design that let them through would move the address or corrupt memory.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
   localparam logic [2:0] OFS_CMD    = 3'd0;
   localparam logic [2:0] OFS_ADR_LO = 3'd1;
   localparam logic [2:0] OFS_ADR_HI = 3'd2;
   localparam logic [2:0] OFS_CNT_LO = 3'd3;
   localparam logic [2:0] OFS_CNT_HI = 3'd4;
   localparam logic [2:0] OFS_STAT   = 3'd5;
   localparam logic [2:0] OFS_CFG    = 3'd6;

   localparam logic [2:0] OP_READ  = 3'b001;
   localparam logic [2:0] OP_WRITE = 3'b010;

   localparam int BIT_DONE = 6;
   localparam int BIT_HALT = 7;

   typedef enum logic [1:0] {DIR_IDLE = 2'd0, DIR_RD = 2'd1, DIR_WR = 2'd2} dir_e;
endpackage

// File: rtl/rdma_mem.sv
module rdma_mem #(
   parameter int DEPTH  = 1024,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              we,
   input  logic              word,
   input  logic [ADDR_W-1:0] addr,
   input  logic [15:0]       wdata,
   output logic [15:0]       rdata
);
   localparam int IW = $clog2(DEPTH);

   logic [7:0]    mem [DEPTH];
   logic [IW-1:0] lo_idx;
   logic [IW-1:0] hi_idx;

   always_comb begin
      lo_idx = word ? {addr[IW-1:1], 1'b0} : addr[IW-1:0];
      hi_idx = {lo_idx[IW-1:1], 1'b1};
      rdata  = word ? {mem[hi_idx], mem[lo_idx]} : {8'h00, mem[lo_idx]};
   end

   always_ff @(posedge clk) begin
      if (we) begin
         mem[lo_idx] <= wdata[7:0];
         if (word) mem[hi_idx] <= wdata[15:8];
      end
   end
endmodule

// File: rtl/rdma_flags.sv
module rdma_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic set_done,
   input  logic w1c_done,
   input  logic set_halt,
   input  logic clr_halt,
   output logic done,
   output logic halted
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done   <= 1'b0;
         halted <= 1'b0;
      end else begin
         done   <= set_done | (done & ~w1c_done);
         halted <= set_halt | (halted & ~clr_halt);
      end
   end

   // R5: a write-one to the flag clears it unless completion arrives together
   assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (w1c_done && !set_done) |=> !done);

   // R11: a stop request is reported on the following cycle
   assert_halt_reported_R11: assert property (@(posedge clk) disable iff (!rst_n)
      set_halt |=> halted);
endmodule

// File: rtl/rdma_seq.sv
module rdma_seq
   import rdma_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_mode,
   input  logic [7:0]        host_byte,
   input  logic              ld_adr_lo,
   input  logic              ld_adr_hi,
   input  logic              ld_cnt_lo,
   input  logic              ld_cnt_hi,
   input  logic              go_read,
   input  logic              go_write,
   input  logic              kill,
   input  logic              port_rd,
   input  logic              port_wr,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [CNT_W-1:0]  rem_cnt,
   output dir_e              dir,
   output logic              mem_we,
   output logic              finish
);
   logic             go;
   logic             accept;
   logic             last;
   logic [CNT_W-1:0] step_c;
   logic [CNT_W-1:0] rounded;

   always_comb begin
      go      = go_read | go_write;
      step_c  = word_mode ? CNT_W'(2) : CNT_W'(1);
      rounded = rem_cnt + (word_mode ? CNT_W'(rem_cnt[0]) : '0);
      accept  = !kill && !go &&
                ((dir == DIR_RD && port_rd) || (dir == DIR_WR && port_wr));
      last    = rem_cnt <= step_c;
      finish  = (!kill && go && rounded == '0) || (accept && last);
      mem_we  = accept && dir == DIR_WR;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_addr <= '0;
         rem_cnt  <= '0;
         dir      <= DIR_IDLE;
      end else begin
         if (kill) begin
            dir <= DIR_IDLE;
         end else if (go) begin
            rem_cnt <= rounded;
            dir     <= (rounded == '0) ? DIR_IDLE : (go_read ? DIR_RD : DIR_WR);
         end else if (accept) begin
            cur_addr <= cur_addr + ADDR_W'(step_c);
            rem_cnt  <= last ? '0 : rem_cnt - step_c;
            if (last) dir <= DIR_IDLE;
         end
         if (ld_adr_lo) cur_addr[7:0]        <= host_byte;
         if (ld_adr_hi) cur_addr[ADDR_W-1:8] <= host_byte[ADDR_W-9:0];
         if (ld_cnt_lo) rem_cnt[7:0]         <= host_byte;
         if (ld_cnt_hi) rem_cnt[CNT_W-1:8]   <= host_byte[CNT_W-9:0];
      end
   end

   // R3: an accepted strobe moves the address by exactly one unit
   assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !ld_adr_lo && !ld_adr_hi) |=>
         cur_addr == $past(cur_addr) + ADDR_W'($past(step_c)));

   // R9: with nothing armed and no host load, pointers hold
   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dir == DIR_IDLE && !go && !ld_adr_lo && !ld_adr_hi && !ld_cnt_lo && !ld_cnt_hi)
         |=> ($stable(cur_addr) && $stable(rem_cnt)));

   // R7: arming in 16-bit mode always leaves an even count
   assert_even_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (go && word_mode && !kill) |=> !rem_cnt[0]);

   // R5: completion leaves the engine idle
   assert_finish_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      finish |=> dir == DIR_IDLE);
endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
   import rdma_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int CNT_W     = 16,
   parameter int MEM_DEPTH = 1024,
   parameter bit WORD_EN   = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [2:0]  reg_addr,
   input  logic        reg_we,
   input  logic [7:0]  reg_wdata,
   output logic [7:0]  reg_rdata,
   input  logic        port_rd,
   input  logic        port_wr,
   input  logic [15:0] port_wdata,
   output logic [15:0] port_rdata,
   output logic        irq
);
   localparam int IW = $clog2(MEM_DEPTH);

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
         $error("ADDR_W must lie in 9..16");
      end
      if (CNT_W < 9 || CNT_W > 16) begin : g_bad_cnt
         $error("CNT_W must lie in 9..16");
      end
      if (MEM_DEPTH < 2 || (1 << IW) != MEM_DEPTH || IW > ADDR_W) begin : g_bad_depth
         $error("MEM_DEPTH must be a power of two that fits the address");
      end
   endgenerate

   logic              cfg_word_q;
   logic              word_eff;
   logic              cmd_wr;
   logic [2:0]        op;
   logic              kill;
   logic              go_read;
   logic              go_write;
   logic [ADDR_W-1:0] cur_addr;
   logic [CNT_W-1:0]  rem_cnt;
   dir_e              dir;
   logic              mem_we;
   logic              finish;
   logic              done;
   logic              halted;
   logic [15:0]       mem_rdata;
   logic [15:0]       addr16;
   logic [15:0]       cnt16;
   logic [2:0]        dir_code;

   generate
      if (WORD_EN) begin : g_word
         assign word_eff = cfg_word_q;
      end else begin : g_byte_only
         assign word_eff = 1'b0;
      end
   endgenerate

   always_comb begin
      cmd_wr   = reg_we && reg_addr == OFS_CMD;
      op       = reg_wdata[5:3];
      kill     = cmd_wr && (reg_wdata[0] || op[2]);
      go_read  = cmd_wr && !reg_wdata[0] && op == OP_READ;
      go_write = cmd_wr && !reg_wdata[0] && op == OP_WRITE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            cfg_word_q <= 1'b0;
      else if (reg_we && reg_addr == OFS_CFG) cfg_word_q <= reg_wdata[0];
   end

   rdma_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .word_mode (word_eff),
      .host_byte (reg_wdata),
      .ld_adr_lo (reg_we && reg_addr == OFS_ADR_LO),
      .ld_adr_hi (reg_we && reg_addr == OFS_ADR_HI),
      .ld_cnt_lo (reg_we && reg_addr == OFS_CNT_LO),
      .ld_cnt_hi (reg_we && reg_addr == OFS_CNT_HI),
      .go_read   (go_read),
      .go_write  (go_write),
      .kill      (kill),
      .port_rd   (port_rd),
      .port_wr   (port_wr),
      .cur_addr  (cur_addr),
      .rem_cnt   (rem_cnt),
      .dir       (dir),
      .mem_we    (mem_we),
      .finish    (finish)
   );

   rdma_flags u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_done (finish),
      .w1c_done (reg_we && reg_addr == OFS_STAT && reg_wdata[BIT_DONE]),
      .set_halt (cmd_wr && reg_wdata[0]),
      .clr_halt ((cmd_wr && reg_wdata[1] && !reg_wdata[0]) ||
                 (reg_we && reg_addr == OFS_STAT && reg_wdata[BIT_HALT])),
      .done     (done),
      .halted   (halted)
   );

   rdma_mem #(.DEPTH(MEM_DEPTH), .ADDR_W(ADDR_W)) u_mem (
      .clk   (clk),
      .we    (mem_we),
      .word  (word_eff),
      .addr  (cur_addr),
      .wdata (port_wdata),
      .rdata (mem_rdata)
   );

   always_comb begin
      addr16     = 16'(cur_addr);
      cnt16      = 16'(rem_cnt);
      dir_code   = (dir == DIR_RD) ? OP_READ : (dir == DIR_WR) ? OP_WRITE : 3'b000;
      port_rdata = (dir == DIR_RD) ? mem_rdata : 16'h0000;
      irq        = done;
      unique case (reg_addr)
         OFS_CMD:    reg_rdata = {2'b00, dir_code, 1'b0, ~halted, halted};
         OFS_ADR_LO: reg_rdata = addr16[7:0];
         OFS_ADR_HI: reg_rdata = addr16[15:8];
         OFS_CNT_LO: reg_rdata = cnt16[7:0];
         OFS_CNT_HI: reg_rdata = cnt16[15:8];
         OFS_STAT:   reg_rdata = {halted, done, 6'b0};
         OFS_CFG:    reg_rdata = {7'b0, word_eff};
         default:    reg_rdata = 8'h00;
      endcase
   end

   // R8: an abort or stop never raises the completion flag
   assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (kill && !done) |=> !done);

   // R9: an idle engine never writes the packet memory
   assert_idle_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dir == DIR_IDLE) |-> !mem_we);
endmodule

// File: tb/rdma_port_engine_tb.sv
module rdma_port_engine_tb;
   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        port_rd = 1'b0;
   logic        port_wr = 1'b0;
   logic [15:0] port_wdata = '0;
   logic [15:0] port_rdata;
   logic        irq;

   int vecs = 0;
   int errs = 0;
   bit live = 1'b0;
   bit ended = 1'b0;

   // reference model state
   int m_addr = 0, m_cnt = 0, m_dir = 0, m_done = 0, m_halt = 0, m_word = 0;
   logic [7:0] m_mem [1024];

   always #(PERIOD/2) clk = ~clk;

   rdma_port_engine u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .port_rd(port_rd),
      .port_wr(port_wr), .port_wdata(port_wdata), .port_rdata(port_rdata),
      .irq(irq)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic int m_read(int a);
      int code;
      code = (m_dir == 1) ? 1 : (m_dir == 2) ? 2 : 0;
      case (a)
         0: return (code << 3) | ((m_halt ? 0 : 1) << 1) | m_halt;
         1: return m_addr & 'hFF;
         2: return (m_addr >> 8) & 'hFF;
         3: return m_cnt & 'hFF;
         4: return (m_cnt >> 8) & 'hFF;
         5: return (m_halt << 7) | (m_done << 6);
         6: return m_word;
         default: return 0;
      endcase
   endfunction

   function automatic void m_regwr(int a, int d);
      int op;
      case (a)
         0: begin
            op = (d >> 3) & 7;
            if (d & 1) begin
               m_dir = 0; m_halt = 1;
            end else begin
               if (d & 2) m_halt = 0;
               if (op & 4) m_dir = 0;
               else if (op == 1 || op == 2) begin
                  if (m_word != 0 && (m_cnt & 1) != 0) m_cnt = (m_cnt + 1) & 'hFFFF;
                  if (m_cnt == 0) begin m_done = 1; m_dir = 0; end
                  else m_dir = op;
               end
            end
         end
         1: m_addr = (m_addr & 'hFF00) | d;
         2: m_addr = (m_addr & 'h00FF) | (d << 8);
         3: m_cnt  = (m_cnt & 'hFF00) | d;
         4: m_cnt  = (m_cnt & 'h00FF) | (d << 8);
         5: begin
            if (d & 'h40) m_done = 0;
            if (d & 'h80) m_halt = 0;
         end
         6: m_word = d & 1;
         default: ;
      endcase
   endfunction

   function automatic int m_base();
      return m_word != 0 ? (m_addr & 'h3FE) : (m_addr & 'h3FF);
   endfunction

   function automatic logic [15:0] m_prd();
      if (m_dir != 1) return 16'h0000;
      if (m_word != 0) return {m_mem[m_base() + 1], m_mem[m_base()]};
      return {8'h00, m_mem[m_base()]};
   endfunction

   function automatic void m_port(bit isw, int d);
      int step;
      step = m_word != 0 ? 2 : 1;
      if ((m_dir == 2 && isw) || (m_dir == 1 && !isw)) begin
         if (isw) begin
            m_mem[m_base()] = d[7:0];
            if (m_word != 0) m_mem[m_base() + 1] = d[15:8];
         end
         m_addr = (m_addr + step) & 'hFFFF;
         if (m_cnt <= step) begin m_cnt = 0; m_done = 1; m_dir = 0; end
         else m_cnt = m_cnt - step;
      end
   endfunction

   task automatic wreg(int a, int d);
      @(negedge clk);
      reg_addr = 3'(a); reg_wdata = 8'(d); reg_we = 1'b1;
      @(posedge clk); #1;
      reg_we = 1'b0;
      m_regwr(a, d);
   endtask

   task automatic rreg(int a, string tag);
      @(negedge clk);
      reg_addr = 3'(a);
      #1;
      chk(tag, 32'(reg_rdata), 32'(m_read(a)));
   endtask

   task automatic pwr(int d);
      @(negedge clk);
      port_wr = 1'b1; port_wdata = 16'(d);
      @(posedge clk); #1;
      port_wr = 1'b0;
      m_port(1'b1, d);
   endtask

   task automatic prd(string tag);
      @(negedge clk);
      port_rd = 1'b1;
      #1;
      chk(tag, 32'(port_rdata), 32'(m_prd()));
      @(posedge clk); #1;
      port_rd = 1'b0;
      m_port(1'b0, 0);
   endtask

   task automatic setup(int adr, int cnt);
      wreg(1, adr & 'hFF);
      wreg(2, (adr >> 8) & 'hFF);
      wreg(3, cnt & 'hFF);
      wreg(4, (cnt >> 8) & 'hFF);
   endtask

   // per-clock comparison of the interrupt line against the model (R5)
   always @(negedge clk) begin
      if (live && !ended) chk("R5 irq", 32'(irq), 32'(m_done));
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!ended) begin
         errs++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      live  = 1'b1;

      // R1 reset state
      for (int a = 0; a < 7; a++) rreg(a, "R1 reset readback");

      // R2 byte-wise loading of address and count
      setup('h0120, 5);
      for (int a = 1; a < 5; a++) rreg(a, "R2 load readback");

      // R3 remote write in byte mode, R10 live address
      wreg(0, 'h12);
      rreg(0, "R13 write armed");
      pwr('h11); pwr('h22);
      rreg(1, "R10 live address low");
      rreg(3, "R3 count after two");
      pwr('h33); pwr('h44);
      rreg(5, "R5 not yet complete");
      pwr('h55);
      rreg(5, "R5 complete flag");
      rreg(0, "R5 idle after complete");
      rreg(1, "R3 address after five");

      // R9 stray strobe after completion
      pwr('hEE);
      rreg(1, "R9 address unchanged");
      rreg(3, "R9 count unchanged");

      // R5 write-zero keeps flag, write-one clears
      wreg(5, 'h00);
      rreg(5, "R5 zero write keeps flag");
      wreg(5, 'h40);
      rreg(5, "R5 w1c clears flag");

      // R4 remote read of the bytes just written
      setup('h0120, 5);
      wreg(0, 'h0A);
      rreg(0, "R13 read armed");
      for (int i = 0; i < 5; i++) prd("R4 read byte");
      rreg(5, "R4 read completes");
      wreg(5, 'h40);

      // R9 idle strobe must not write memory
      setup('h0124, 1);
      pwr('h77);
      prd("R9 idle read is zero");
      wreg(0, 'h0A);
      prd("R9 memory kept old byte");
      wreg(5, 'h40);

      // R6, R7 word mode with odd count
      wreg(6, 1);
      rreg(6, "R6 config readback");
      setup('h0200, 3);
      wreg(0, 'h12);
      rreg(3, "R7 count rounded up");
      pwr('hB2A1);
      rreg(1, "R6 address steps by two");
      pwr('hD4C3);
      rreg(5, "R6 word transfer completes");
      wreg(5, 'h40);
      wreg(6, 0);
      setup('h0201, 1);
      wreg(0, 'h0A);
      prd("R6 high byte at odd address");
      wreg(5, 'h40);
      wreg(6, 1);
      setup('h0200, 4);
      wreg(0, 'h0A);
      prd("R6 word read 0");
      prd("R6 word read 1");
      wreg(5, 'h40);
      wreg(6, 0);

      // R8 abort
      setup('h0120, 10);
      wreg(0, 'h0A);
      prd("R8 read before abort");
      wreg(0, 'h22);
      rreg(0, "R8 idle after abort");
      rreg(5, "R8 no flag after abort");
      prd("R8 port quiet after abort");
      rreg(1, "R8 address held");

      // R12 send code arms nothing
      setup('h0130, 4);
      wreg(0, 'h1A);
      rreg(0, "R12 no transfer armed");
      pwr('h99);
      rreg(3, "R12 count unchanged");

      // R11 stop and restart
      setup('h0140, 2);
      wreg(0, 'h12);
      wreg(0, 'h01);
      rreg(5, "R11 halt bit set");
      rreg(0, "R11 disarmed by stop");
      pwr('h66);
      rreg(3, "R11 count held after stop");
      wreg(0, 'h02);
      rreg(5, "R11 start clears halt");
      rreg(0, "R11 command after start");

      // R5 zero-count arming completes at once
      setup('h0150, 0);
      wreg(0, 'h0A);
      rreg(5, "R5 zero count completes");
      rreg(0, "R5 zero count idle");
      wreg(5, 'h40);
      rreg(5, "R5 cleared again");

      repeat (2) @(negedge clk);
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule